// File: doc/BRIEF.md
# Hint-Steered Partitioned Data Cache

This block is a small write-back data cache split into four independent direct-mapped partitions of equal shape. Each load or store arrives with two 4-bit masks from the instruction. The probe mask says which partitions take part in the tag and data lookup. The placement mask says which partitions may take the line when the access misses. A partition outside the probe mask leaves its tag and data arrays idle for that access. The hardware never probes all ways by default and never picks a victim from outside the placement mask.

When software keeps data streams in separate partitions, accesses that would collide in a direct-mapped array stay resident side by side. The hit behaviour then comes close to that of a fully associative cache of the same size, while most array reads are avoided. A per-partition probe counter lets a bench confirm that the masks really suppress array activity. The CPU side uses a valid/ready handshake that holds the request until it completes. The memory side moves whole lines, one transfer at a time, and each transfer is acknowledged.

Top module: `pcache_top`

## Requirements
- R1: A word address splits into three fields that are the same in every partition: bits [1:0] pick the word within a 4-word line, bits [4:2] pick one of 8 sets, and the remaining upper bits form the tag; the line address sent to memory is the word address shifted right by 2.
- R2: A request whose line is valid in a partition whose bit is set in `req_look` (bit p selects partition p) completes in the cycle it is first presented: `req_ready` and `resp_hit` are 1, and `resp_rdata` carries the addressed word.
- R3: A copy of the line held only in partitions whose `req_look` bit is clear does not produce a hit; the access is handled as a miss.
- R4: When several probed partitions hold the line, the lowest-numbered one supplies the read data and receives a store.
- R5: An all-zero `req_look` always misses and still refills the line; no probe counter advances for it.
- R6: On a miss the line goes into a partition whose bit is set in `req_fill`; an all-zero `req_fill` allows all four partitions.
- R7: Victim choice takes the lowest-numbered invalid allowed partition. If none is invalid, a per-set pointer (reset value 0) is the starting point, the first allowed partition at or above it in cyclic order is taken, and the pointer then moves to that partition plus one, modulo 4.
- R8: A store hit updates only the addressed word, marks the line dirty and causes no memory transfer.
- R9: A dirty victim is first written to memory as a whole line (`mem_write`=1, the victim's own line address). The read of the new line is requested only after that write is acknowledged.
- R10: On a miss the line is read from memory and installed. The request completes in the cycle after the read acknowledge, with `resp_hit`=0 and the addressed word on `resp_rdata`. A store miss merges its word into the line and leaves it dirty.
- R11: `probe_cnt` holds one 16-bit counter per partition (partition p in bits [16p+15:16p]). Each request adds exactly one to the counter of each partition in its `req_look` and leaves the others unchanged.
- R12: Once `mem_valid` rises, `mem_addr` and `mem_write` stay constant until `mem_ack` is seen.
- R13: After reset all lines are invalid, every counter is 0, and `req_ready` and `mem_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request present; held until req_ready |
| req_ready | output | 1 | Request completes this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Store data |
| req_look | input | 4 | Partitions probed for a hit |
| req_fill | input | 4 | Partitions allowed to take the line on a miss |
| resp_hit | output | 1 | The completing request hit |
| resp_rdata | output | 32 | Load data, valid with req_ready |
| mem_valid | output | 1 | Line transfer requested |
| mem_write | output | 1 | 1 = write-back of a line, 0 = refill read |
| mem_addr | output | 14 | Line address |
| mem_wline | output | 128 | Line written back, word 0 in the low bits |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rline | input | 128 | Refill data, valid with mem_ack |
| probe_cnt | output | 64 | Per-partition probe counters |

## Verification
Wrong tags, valid bits or dirty bits show up at the ports on the next access to the affected set. They appear as a hit where a miss was due or the reverse, as a missing or extra write-back, or as stale load data. A bad round-robin pointer shows one eviction later, when a line expected to stay resident misses. A probe mask that is not honoured shows up in the probe counters in the cycle after the lookup, or as a hit coming from a partition that was not probed. The bench keeps its own model of every partition, the memory and the pointers. It compares hit status, data, transfer order and counters after each request, so any divergence is reported within the request that caused it.

// File: rtl/pcache_pkg.sv
// Shared types for the partitioned cache.
package pcache_pkg;
    // Controller states: lookup, write-back of a victim, refill, reply.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2,
        ST_REPLY  = 2'd3
    } pc_state_e;
endpackage

// File: rtl/pcache_part.sv
// One direct-mapped partition: tag, data, valid and dirty state per set.
// Assumes store and fill never target the same partition in one cycle.
// Tag and data are only read when the matching enable is high.
module pcache_part #(
    parameter int SETS  = 8,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int TAGB  = 11,
    localparam int IDXB = $clog2(SETS),
    localparam int OFFB = $clog2(WORDS),
    localparam int LW   = WORDS * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            probe_en,
    input  logic            evict_en,
    input  logic [IDXB-1:0] idx,
    input  logic [TAGB-1:0] tag,
    input  logic [OFFB-1:0] off,
    output logic            hit,
    output logic [DW-1:0]   rd_word,
    output logic [LW-1:0]   line_o,
    output logic [TAGB-1:0] vtag_o,
    output logic            valid_o,
    output logic            dirty_o,
    input  logic            store_en,
    input  logic [DW-1:0]   store_data,
    input  logic            fill_en,
    input  logic [TAGB-1:0] fill_tag,
    input  logic [LW-1:0]   fill_line,
    input  logic            fill_dirty
);
    logic [TAGB-1:0] tag_q  [SETS];
    logic [LW-1:0]   data_q [SETS];
    logic [SETS-1:0] vld_q;
    logic [SETS-1:0] dty_q;

    // Gated lookup: no array read unless the partition is probed.
    always_comb begin
        hit     = probe_en && vld_q[idx] && (tag_q[idx] == tag);
        rd_word = probe_en ? data_q[idx][int'(off)*DW +: DW] : '0;
    end

    // Gated victim read for write-back.
    always_comb begin
        line_o  = evict_en ? data_q[idx] : '0;
        vtag_o  = evict_en ? tag_q[idx]  : '0;
        valid_o = vld_q[idx];
        dirty_o = dty_q[idx];
    end

    // Status bits: cleared by reset, set by fill, dirtied by store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            dty_q <= '0;
        end else if (fill_en) begin
            vld_q[idx] <= 1'b1;
            dty_q[idx] <= fill_dirty;
        end else if (store_en) begin
            dty_q[idx] <= 1'b1;
        end
    end

    // Tag and data arrays: written on fill or store hit.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= fill_tag;
            data_q[idx] <= fill_line;
        end else if (store_en) begin
            data_q[idx][int'(off)*DW +: DW] <= store_data;
        end
    end
endmodule

// File: rtl/pcache_victim.sv
// Victim selection among allowed partitions: lowest invalid first,
// otherwise cyclic search from a per-set pointer. Assumes NPART is a
// power of two of at least 2.
module pcache_victim #(
    parameter int NPART = 4,
    parameter int SETS  = 8,
    localparam int PW   = $clog2(NPART),
    localparam int IDXB = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDXB-1:0]  idx,
    input  logic [NPART-1:0] fill_mask,
    input  logic [NPART-1:0] valid_vec,
    input  logic             commit,
    output logic [PW-1:0]    victim
);
    logic [PW-1:0]    rr_q [SETS];
    logic [NPART-1:0] allow;
    logic [NPART-1:0] inv;
    logic             found;
    logic             use_rr;
    logic [PW-1:0]    cand;

    // Pick the victim for the current set.
    always_comb begin
        allow  = (fill_mask == '0) ? '1 : fill_mask;
        inv    = allow & ~valid_vec;
        victim = '0;
        found  = 1'b0;
        use_rr = 1'b0;
        cand   = '0;
        for (int p = 0; p < NPART; p++) begin
            if (inv[p] && !found) begin
                victim = PW'(p);
                found  = 1'b1;
            end
        end
        if (!found) begin
            use_rr = 1'b1;
            for (int k = 0; k < NPART; k++) begin
                cand = rr_q[idx] + PW'(k);
                if (allow[cand] && !found) begin
                    victim = cand;
                    found  = 1'b1;
                end
            end
        end
    end

    // Advance the set pointer past a victim chosen by rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (commit && use_rr) begin
            rr_q[idx] <= victim + PW'(1);
        end
    end
endmodule

// File: rtl/pcache_probe_cnt.sv
// One saturating-free wrap counter per partition, advanced by its probe
// enable. Assumes at most one increment per partition per cycle.
module pcache_probe_cnt #(
    parameter int NPART = 4,
    parameter int CW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPART-1:0]    inc,
    output logic [NPART*CW-1:0] cnt_flat
);
    for (genvar p = 0; p < NPART; p++) begin : g_cnt
        logic [CW-1:0] c_q;
        // Count probe cycles of partition p.
        always_ff @(posedge clk) begin
            if (!rst_n)      c_q <= '0;
            else if (inc[p]) c_q <= c_q + CW'(1);
        end
        assign cnt_flat[p*CW +: CW] = c_q;
    end
endmodule

// File: rtl/pcache_top.sv
// Partitioned data cache steered by per-access probe and placement masks.
// Assumes the CPU holds req_* stable while req_valid is high and
// req_ready is low. One miss is handled at a time; the memory side moves
// whole lines and completes each transfer with mem_ack.
module pcache_top
    import pcache_pkg::*;
#(
    parameter int NPART = 4,
    parameter int SETS  = 8,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int CW    = 16,
    localparam int IDXB = $clog2(SETS),
    localparam int OFFB = $clog2(WORDS),
    localparam int TAGB = AW - IDXB - OFFB,
    localparam int PW   = $clog2(NPART),
    localparam int LW   = WORDS * DW,
    localparam int LAW  = AW - OFFB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  logic [NPART-1:0]    req_look,
    input  logic [NPART-1:0]    req_fill,
    output logic                resp_hit,
    output logic [DW-1:0]       resp_rdata,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [LAW-1:0]      mem_addr,
    output logic [LW-1:0]       mem_wline,
    input  logic                mem_ack,
    input  logic [LW-1:0]       mem_rline,
    output logic [NPART*CW-1:0] probe_cnt
);
    pc_state_e state_q;
    logic [PW-1:0]   vic_q;
    logic [DW-1:0]   reply_q;

    logic [OFFB-1:0] off;
    logic [IDXB-1:0] idx;
    logic [TAGB-1:0] tag;

    logic [NPART-1:0] probe_en, evict_en, store_en, fill_en;
    logic [NPART-1:0] part_hit, part_valid, part_dirty;
    logic [DW-1:0]    pw_word [NPART];
    logic [LW-1:0]    pw_line [NPART];
    logic [TAGB-1:0]  pw_vtag [NPART];

    logic            any_hit, miss_go;
    logic [PW-1:0]   hit_sel, vic_sel;
    logic [DW-1:0]   sel_word;
    logic [LW-1:0]   ev_line, fill_line;
    logic [TAGB-1:0] ev_tag;

    // Address fields shared by every partition.
    assign off = req_addr[OFFB-1:0];
    assign idx = req_addr[OFFB +: IDXB];
    assign tag = req_addr[AW-1 -: TAGB];

    // Per-partition enables derived from state and masks.
    always_comb begin
        for (int p = 0; p < NPART; p++) begin
            probe_en[p] = (state_q == ST_IDLE) && req_valid && req_look[p];
            evict_en[p] = (state_q == ST_EVICT) && (vic_q == PW'(p));
            fill_en[p]  = (state_q == ST_REFILL) && mem_ack && (vic_q == PW'(p));
            store_en[p] = (state_q == ST_IDLE) && req_valid && req_write
                          && any_hit && (hit_sel == PW'(p));
        end
    end

    // Merge the store word into the refill line on a store miss.
    always_comb begin
        fill_line = mem_rline;
        if (req_write) fill_line[int'(off)*DW +: DW] = req_wdata;
    end

    for (genvar p = 0; p < NPART; p++) begin : g_part
        pcache_part #(
            .SETS(SETS), .WORDS(WORDS), .DW(DW), .TAGB(TAGB)
        ) u_part (
            .clk        (clk),
            .rst_n      (rst_n),
            .probe_en   (probe_en[p]),
            .evict_en   (evict_en[p]),
            .idx        (idx),
            .tag        (tag),
            .off        (off),
            .hit        (part_hit[p]),
            .rd_word    (pw_word[p]),
            .line_o     (pw_line[p]),
            .vtag_o     (pw_vtag[p]),
            .valid_o    (part_valid[p]),
            .dirty_o    (part_dirty[p]),
            .store_en   (store_en[p]),
            .store_data (req_wdata),
            .fill_en    (fill_en[p]),
            .fill_tag   (tag),
            .fill_line  (fill_line),
            .fill_dirty (req_write)
        );
    end

    // Lowest-numbered hitting partition wins.
    always_comb begin
        any_hit = |part_hit;
        hit_sel = '0;
        for (int p = NPART - 1; p >= 0; p--) begin
            if (part_hit[p]) hit_sel = PW'(p);
        end
        sel_word = pw_word[hit_sel];
    end

    // Victim line and tag: only the evicting partition drives non-zero.
    always_comb begin
        ev_line = '0;
        ev_tag  = '0;
        for (int p = 0; p < NPART; p++) begin
            ev_line = ev_line | pw_line[p];
            ev_tag  = ev_tag  | pw_vtag[p];
        end
    end

    assign miss_go = (state_q == ST_IDLE) && req_valid && !any_hit;

    pcache_victim #(.NPART(NPART), .SETS(SETS)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .fill_mask (req_fill),
        .valid_vec (part_valid),
        .commit    (miss_go),
        .victim    (vic_sel)
    );

    pcache_probe_cnt #(.NPART(NPART), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (probe_en),
        .cnt_flat (probe_cnt)
    );

    // Miss controller: lookup, optional write-back, refill, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vic_q   <= '0;
            reply_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (miss_go) begin
                    vic_q   <= vic_sel;
                    state_q <= (part_valid[vic_sel] && part_dirty[vic_sel])
                               ? ST_EVICT : ST_REFILL;
                end
                ST_EVICT:  if (mem_ack) state_q <= ST_REFILL;
                ST_REFILL: if (mem_ack) begin
                    reply_q <= mem_rline[int'(off)*DW +: DW];
                    state_q <= ST_REPLY;
                end
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // CPU response.
    always_comb begin
        req_ready  = (state_q == ST_REPLY) || ((state_q == ST_IDLE) && req_valid && any_hit);
        resp_hit   = (state_q == ST_IDLE) && req_valid && any_hit;
        resp_rdata = (state_q == ST_REPLY) ? reply_q : (resp_hit ? sel_word : '0);
    end

    // Memory request.
    always_comb begin
        mem_valid = (state_q == ST_EVICT) || (state_q == ST_REFILL);
        mem_write = (state_q == ST_EVICT);
        mem_addr  = (state_q == ST_EVICT) ? {ev_tag, idx} : {tag, idx};
        mem_wline = ev_line;
    end
endmodule

// File: rtl/pcache_chk.sv
// Protocol and mask checks for pcache_top, attached by bind.
module pcache_chk #(
    parameter int NPART = 4,
    parameter int LAW   = 14,
    parameter int CW    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                resp_hit,
    input logic [NPART-1:0]    req_look,
    input logic                mem_valid,
    input logic                mem_write,
    input logic                mem_ack,
    input logic [LAW-1:0]      mem_addr,
    input logic [NPART-1:0]    probe_en,
    input logic [NPART-1:0]    part_hit,
    input logic [NPART*CW-1:0] probe_cnt
);
    for (genvar p = 0; p < NPART; p++) begin : g_p
        // R3: a partition reports a hit only while it is probed.
        a_r3_hit_needs_probe: assert property (@(posedge clk) disable iff (!rst_n)
            part_hit[p] |-> probe_en[p]);
    end

    // R5: an empty probe mask never completes as a hit.
    a_r5_empty_mask_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (req_look == '0) |-> !resp_hit);

    // R12: memory request held until acknowledged.
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    // R9: an acknowledged write-back is followed by the refill read.
    a_r9_refill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && mem_ack) |=> (mem_valid && !mem_write));

    // R10: the request completes as a miss right after the refill.
    a_r10_reply_after_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write && mem_ack) |=> (req_ready && !resp_hit));

    // R11: counters hold while no request is presented.
    a_r11_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(probe_cnt));
endmodule

bind pcache_top pcache_chk #(.NPART(NPART), .LAW(LAW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .resp_hit  (resp_hit),
    .req_look  (req_look),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .probe_en  (probe_en),
    .part_hit  (part_hit),
    .probe_cnt (probe_cnt)
);

// File: tb/tb_pcache_top.sv
`timescale 1ns/1ps
// Bench with a behavioural model of partitions, pointers and memory.
module tb_pcache_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_look = '0;
    logic [3:0]   req_fill = '0;
    logic         resp_hit;
    logic [31:0]  resp_rdata;
    logic         mem_valid;
    logic         mem_write;
    logic [13:0]  mem_addr;
    logic [127:0] mem_wline;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rline = '0;
    logic [63:0]  probe_cnt;

    always #10 clk = ~clk;

    pcache_top dut (.*);

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // Model state.
    int          mtag [4][8];
    bit          mv   [4][8];
    bit          md   [4][8];
    logic [31:0] mdat [4][8][4];
    int          rr   [8];
    int          mcnt [4];
    logic [31:0] mm   [int];   // model memory
    logic [31:0] bm   [int];   // responder memory

    int           exp_a[$], act_a[$];
    bit           exp_w[$], act_w[$];
    logic [127:0] exp_d[$], act_d[$];

    function automatic logic [31:0] init_word(int a);
        return (a * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [31:0] mm_rd(int a);
        if (mm.exists(a)) return mm[a];
        return init_word(a);
    endfunction

    function automatic logic [31:0] bm_rd(int a);
        if (bm.exists(a)) return bm[a];
        return init_word(a);
    endfunction

    task automatic check(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Memory responder: acknowledges each transfer after two waiting cycles.
    initial begin
        int wait_n = 0;
        logic [13:0] first_a = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wait_n  = 0;
            end else if (mem_valid) begin
                if (wait_n == 0) first_a = mem_addr;
                wait_n++;
                if (wait_n >= 2) begin
                    check(mem_addr == first_a, "R12", "address held", mem_addr, first_a);
                    act_a.push_back(int'(mem_addr));
                    act_w.push_back(mem_write);
                    act_d.push_back(mem_write ? mem_wline : 128'd0);
                    if (mem_write) begin
                        for (int w = 0; w < 4; w++) bm[int'(mem_addr)*4 + w] = mem_wline[w*32 +: 32];
                    end else begin
                        for (int w = 0; w < 4; w++) mem_rline[w*32 +: 32] = bm_rd(int'(mem_addr)*4 + w);
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // One request: predict with the model, drive, then compare.
    task automatic req(bit wr, int addr, logic [31:0] wd, logic [3:0] look, logic [3:0] fill, string rq);
        int off = addr % 4;
        int idx = (addr / 4) % 8;
        int tg  = addr / 32;
        int hp  = -1;
        int vic = -1;
        int cyc = 0;
        bit exp_hit;
        logic [31:0] exp_rd;
        logic [3:0]  m;
        logic [127:0] ln;
        for (int p = 0; p < 4; p++) begin
            if (look[p]) mcnt[p]++;
            if (look[p] && mv[p][idx] && mtag[p][idx] == tg && hp < 0) hp = p;
        end
        exp_hit = (hp >= 0);
        if (exp_hit) begin
            exp_rd = mdat[hp][idx][off];
            if (wr) begin
                mdat[hp][idx][off] = wd;
                md[hp][idx] = 1'b1;
            end
        end else begin
            m = (fill == 4'd0) ? 4'hF : fill;
            for (int p = 0; p < 4; p++) if (m[p] && !mv[p][idx] && vic < 0) vic = p;
            if (vic < 0) begin
                for (int k = 0; k < 4; k++) begin
                    int c = (rr[idx] + k) % 4;
                    if (m[c] && vic < 0) vic = c;
                end
                rr[idx] = (vic + 1) % 4;
            end
            if (mv[vic][idx] && md[vic][idx]) begin
                for (int w = 0; w < 4; w++) begin
                    ln[w*32 +: 32] = mdat[vic][idx][w];
                    mm[(mtag[vic][idx]*8 + idx)*4 + w] = mdat[vic][idx][w];
                end
                exp_a.push_back(mtag[vic][idx]*8 + idx);
                exp_w.push_back(1'b1);
                exp_d.push_back(ln);
            end
            exp_a.push_back(tg*8 + idx);
            exp_w.push_back(1'b0);
            exp_d.push_back(128'd0);
            for (int w = 0; w < 4; w++) mdat[vic][idx][w] = mm_rd((tg*8 + idx)*4 + w);
            exp_rd = mdat[vic][idx][off];
            if (wr) mdat[vic][idx][off] = wd;
            md[vic][idx]   = wr;
            mv[vic][idx]   = 1'b1;
            mtag[vic][idx] = tg;
        end

        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 16'(addr);
        req_wdata = wd;
        req_look  = look;
        req_fill  = fill;
        forever begin
            #5;
            if (req_ready || cyc > 60) break;
            @(negedge clk);
            cyc++;
        end
        check(req_ready == 1'b1, rq, "request completes", req_ready, 1);
        check(resp_hit == exp_hit, rq, "hit status", resp_hit, exp_hit);
        if (exp_hit) check(cyc == 0, "R2", "hit latency", cyc, 0);
        else         check(cyc > 0, "R10", "miss latency", cyc, 1);
        if (!wr) check(resp_rdata == exp_rd, rq, "R1 load data", resp_rdata, exp_rd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #5;
        check(act_a.size() == exp_a.size(), "R9", "transfer count", act_a.size(), exp_a.size());
        while (exp_a.size() > 0 && act_a.size() > 0) begin
            int ea = exp_a.pop_front();
            int aa = act_a.pop_front();
            bit ew = exp_w.pop_front();
            bit aw = act_w.pop_front();
            logic [127:0] ed = exp_d.pop_front();
            logic [127:0] ad = act_d.pop_front();
            check(aa == ea, "R9", "transfer line address", aa, ea);
            check(aw == ew, "R9", "transfer direction", aw, ew);
            if (ew) check(ad == ed, "R9", "write-back line", ad, ed);
        end
        exp_a.delete(); act_a.delete(); exp_w.delete(); act_w.delete();
        exp_d.delete(); act_d.delete();
        for (int p = 0; p < 4; p++)
            check(probe_cnt[p*16 +: 16] == 16'(mcnt[p]), "R11", $sformatf("probe counter %0d", p),
                  probe_cnt[p*16 +: 16], 16'(mcnt[p]));
    endtask

    function automatic int A(int tg, int idx, int off);
        return tg*32 + idx*4 + off;
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 4; p++) begin
            mcnt[p] = 0;
            for (int s = 0; s < 8; s++) begin mv[p][s] = 0; md[p][s] = 0; mtag[p][s] = 0; end
        end
        for (int s = 0; s < 8; s++) rr[s] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b0, "R13", "ready after reset", req_ready, 0);
        check(mem_valid == 1'b0, "R13", "mem idle after reset", mem_valid, 0);
        check(probe_cnt == 64'd0, "R13", "counters after reset", probe_cnt, 0);
        rst_n = 1'b1;

        req(0, A(3, 1, 2), 0, 4'b0001, 4'b0001, "R10");          // cold miss into P0
        req(0, A(3, 1, 1), 0, 4'b0001, 4'b0001, "R2");           // hit
        req(0, A(3, 1, 0), 0, 4'b0010, 4'b0010, "R3");           // only P1 probed: miss, copy in P1
        req(1, A(3, 1, 0), 32'hDEAD_0001, 4'b0001, 4'b0001, "R8"); // store hit in P0
        req(0, A(3, 1, 0), 0, 4'b0011, 4'b0001, "R4");           // both hit: P0 wins
        req(0, A(3, 1, 0), 0, 4'b0010, 4'b0001, "R4");           // P1 still old
        req(0, A(9, 2, 3), 0, 4'b0000, 4'b0100, "R5");           // forced miss, fills P2
        req(0, A(9, 2, 3), 0, 4'b0000, 4'b0100, "R5");           // still a miss
        req(0, A(9, 2, 3), 0, 4'b0100, 4'b0100, "R6");           // found in P2
        for (int k = 0; k < 4; k++) req(0, A(20 + k, 5, k), 0, 4'(1 << k), 4'(1 << k), "R6");
        for (int k = 0; k < 4; k++) req(0, A(20 + k, 5, 3 - k), 0, 4'(1 << k), 4'(1 << k), "R3");
        for (int k = 0; k < 6; k++) req(0, A(40 + k, 6, 1), 0, 4'hF, 4'h0, "R7");
        for (int k = 0; k < 6; k++) req(0, A(40 + k, 6, 2), 0, 4'hF, 4'h0, "R7");
        req(1, A(20, 5, 2), 32'hBEEF_0002, 4'b0001, 4'b0001, "R8");
        req(0, A(30, 5, 2), 0, 4'b0001, 4'b0001, "R9");          // dirty victim written back
        req(0, A(20, 5, 2), 0, 4'b0001, 4'b0001, "R9");          // reload sees stored word
        req(1, A(50, 7, 1), 32'h1234_5678, 4'b1000, 4'b1000, "R10"); // store miss merge
        req(0, A(50, 7, 1), 0, 4'b1000, 4'b1000, "R10");
        for (int i = 0; i < 300; i++)
            req($urandom_range(0, 1), A($urandom_range(0, 5), $urandom_range(0, 1), $urandom_range(0, 3)),
                $urandom, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), "R7");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule